// File: doc/BRIEF.md
# Connection-Memory Control Bit Serializer

This block keeps one control bit for every output time slot of a sixteen-stream time-slot switch and sends all of those bits out on one serial pin in each frame. The block runs on a serial clock at twice the stream bit rate. One channel period of a data stream therefore lasts sixteen serial clocks, and the pin can carry one bit for each of the sixteen streams in every channel period.

The bits are sent one channel ahead of the slots they control. During channel c of the data streams, the pin sends the bits for channel c+1, stream 0 first and stream 15 last. The bits for channel 0 are sent in the last channel of the frame before. External logic therefore has a full channel period to act on a bit before its slot begins.

The control-bit store is a single-bit-wide array with its own write port, laid out so that it can map onto block RAM. A frame pulse sets the position of the frame and latches the rate code. Between pulses the block counts through the frame on its own.

Top module: `cco_serializer`

## Requirements
- R1: `rate_i` sets the number of channels per frame (cpf). Code 0 gives 32, code 1 gives 64, and codes 2 and 3 both give 128. A frame lasts 16 × cpf serial clocks: 512, 1024 or 2048 bits.
- R2: Frame position k = 16·c + s, with s in 0..15, carries the bit for stream s. Within one channel period the streams go out in ascending order.
- R3: Position 16·c + s carries the stored bit for stream s, channel (c+1) mod cpf, so each bit goes out one channel early. At 32 channels, stream 0 channel 0 goes out at position 496 and stream 1 channel 0 at position 497.
- R4: The bit for stream s, channel ch is stored at address s·cpf + ch. A write with `cm_we_i` high stores `cm_wbit_i` at `cm_waddr_i` on the clock edge.
- R5: When `fp_i` is sampled high on an edge, `cco_o` shows the bit for position 0 in the cycle that follows. Position k then appears k cycles later. A pulse in the middle of a frame restarts the sequence.
- R6: If no frame pulse arrives, the position returns to 0 after the last position of the frame, and the sequence repeats.
- R7: `rate_i` is sampled only on an edge where `fp_i` is high. Changes at any other time do not affect the serial sequence until the next frame pulse.
- R8: While `rst` is high, `cco_o` is 0, the position is set to 0 and the rate falls back to 32 channels. After `rst` is released, positions 0, 1, ... follow at that rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, twice the stream bit rate |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Frame pulse; restarts the position and samples the rate |
| rate_i | input | 2 | Rate code (channels per frame) |
| cm_we_i | input | 1 | Control-bit store write enable |
| cm_waddr_i | input | 11 | Write address, stream·cpf + channel |
| cm_wbit_i | input | 1 | Control bit to write |
| cco_o | output | 1 | Serialized control bit, registered |

## Verification
The bench builds the block with the default sixteen streams and a 32-channel base frame. With these values all three frame lengths can be tested, along with the reserved rate code and a store that is fully used at 2048 entries. At every rate the bench fills the store with random bits and checks every position over two frames, including the wrap with no frame pulse. It also runs directed tests for the early channel-0 bits at the end of a frame, a rate change with no frame pulse, a restart in the middle of a frame, and the state out of reset.

// File: rtl/cco_pkg.sv
package cco_pkg;

  // Rate code to log2(cpf / base); code 3 behaves as code 2.
  function automatic logic [1:0] rate_shift(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/cco_timing.sv
module cco_timing #(
  parameter int NUM_STREAMS = 16,
  parameter int BASE_CH     = 32,
  localparam int ST_BITS    = $clog2(NUM_STREAMS),
  localparam int BASE_BITS  = $clog2(BASE_CH),
  localparam int POS_W      = ST_BITS + BASE_BITS + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fp_i,
  input  logic [1:0]       rate_i,
  output logic [POS_W-1:0] pos_o,
  output logic [1:0]       shift_o
);

  logic [1:0]       rate_q;
  logic [1:0]       shift_eff;
  logic [POS_W-1:0] rd_pos;
  logic [POS_W-1:0] pos_now;
  logic [POS_W-1:0] pos_last;

  function automatic logic [POS_W-1:0] last_of(input logic [1:0] sh);
    logic [POS_W:0] len;
    len = (POS_W+1)'(1) << (ST_BITS + BASE_BITS + int'(sh));
    return POS_W'(len - (POS_W+1)'(1));
  endfunction

  always_comb begin
    shift_eff = fp_i ? cco_pkg::rate_shift(rate_i) : rate_q;
    pos_now   = fp_i ? '0 : rd_pos;
    pos_last  = last_of(shift_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pos <= '0;
      rate_q <= 2'd0;
    end else begin
      rd_pos <= (pos_now == pos_last) ? '0 : pos_now + POS_W'(1);
      rate_q <= shift_eff;
    end
  end

  assign pos_o   = pos_now;
  assign shift_o = shift_eff;

  // R5: after a frame pulse the next read position is 1
  p_fp_restart_r5: assert property (@(posedge clk) disable iff (rst)
    fp_i |=> rd_pos == POS_W'(1));

  // R6: free-running wrap at the end of the frame
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (!fp_i && rd_pos == last_of(rate_q)) |=> rd_pos == '0);

  // R7: rate holds between frame pulses
  p_rate_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !fp_i |=> rate_q == $past(rate_q));

  // R1: position stays inside the frame of the latched rate
  p_pos_bound_r1: assert property (@(posedge clk) disable iff (rst)
    rd_pos <= last_of(rate_q));

endmodule

// File: rtl/cco_addr_map.sv
module cco_addr_map #(
  parameter int NUM_STREAMS = 16,
  parameter int BASE_CH     = 32,
  localparam int ST_BITS    = $clog2(NUM_STREAMS),
  localparam int BASE_BITS  = $clog2(BASE_CH),
  localparam int CH_W       = BASE_BITS + 2,
  localparam int AW         = ST_BITS + CH_W
) (
  input  logic [AW-1:0] pos_i,
  input  logic [1:0]    shift_i,
  output logic [AW-1:0] addr_o
);

  logic [ST_BITS-1:0] strm;
  logic [CH_W-1:0]    ch;
  logic [CH_W-1:0]    ch_mask;
  logic [CH_W-1:0]    ch_nxt;

  always_comb begin
    strm    = pos_i[ST_BITS-1:0];
    ch      = pos_i[AW-1:ST_BITS];
    ch_mask = CH_W'((BASE_CH << int'(shift_i)) - 1);
    ch_nxt  = (ch + CH_W'(1)) & ch_mask;
    addr_o  = (AW'(strm) << (BASE_BITS + int'(shift_i))) | AW'(ch_nxt);
  end

endmodule

// File: rtl/cco_ctrl_ram.sv
module cco_ctrl_ram #(
  parameter int DEPTH = 2048,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_q
);

  logic mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wbit_i;
  end

  always_ff @(posedge clk) begin
    if (rst) rbit_q <= 1'b0;
    else     rbit_q <= mem[raddr_i];
  end

endmodule

// File: rtl/cco_serializer.sv
module cco_serializer #(
  parameter int NUM_STREAMS = 16,
  parameter int BASE_CH     = 32,
  localparam int ST_BITS    = $clog2(NUM_STREAMS),
  localparam int BASE_BITS  = $clog2(BASE_CH),
  localparam int AW         = ST_BITS + BASE_BITS + 2,
  localparam int DEPTH      = NUM_STREAMS * BASE_CH * 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fp_i,
  input  logic [1:0]    rate_i,
  input  logic          cm_we_i,
  input  logic [AW-1:0] cm_waddr_i,
  input  logic          cm_wbit_i,
  output logic          cco_o
);

  logic [AW-1:0] rd_pos;
  logic [1:0]    shift;
  logic [AW-1:0] rd_addr;

  cco_timing #(.NUM_STREAMS(NUM_STREAMS), .BASE_CH(BASE_CH)) u_timing (
    .clk(clk), .rst(rst), .fp_i(fp_i), .rate_i(rate_i),
    .pos_o(rd_pos), .shift_o(shift)
  );

  cco_addr_map #(.NUM_STREAMS(NUM_STREAMS), .BASE_CH(BASE_CH)) u_map (
    .pos_i(rd_pos), .shift_i(shift), .addr_o(rd_addr)
  );

  // Read is issued one clock ahead; the RAM output register is the pin register.
  cco_ctrl_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we_i(cm_we_i), .waddr_i(cm_waddr_i),
    .wbit_i(cm_wbit_i), .raddr_i(rd_addr), .rbit_q(cco_o)
  );

  // R4: read address lies within the store region used by the active rate
  p_addr_range_r4: assert property (@(posedge clk) disable iff (rst)
    {1'b0, rd_addr} < ((AW+1)'(NUM_STREAMS * BASE_CH) << shift));

endmodule

// File: tb/sim_cco_serializer.sv
module sim_cco_serializer;

  localparam int NS = 16;
  localparam int AW = 11;
  localparam int TBL [4][2] = '{'{0, 32}, '{1, 64}, '{2, 128}, '{3, 128}};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fp_i = 1'b0;
  logic [1:0]    rate_i = 2'd0;
  logic          cm_we_i = 1'b0;
  logic [AW-1:0] cm_waddr_i = '0;
  logic          cm_wbit_i = 1'b0;
  logic          cco_o;

  int  checks = 0;
  int  errors = 0;
  logic mdl [0:2047];

  always #4 clk = ~clk;

  cco_serializer u0 (
    .clk(clk), .rst(rst), .fp_i(fp_i), .rate_i(rate_i),
    .cm_we_i(cm_we_i), .cm_waddr_i(cm_waddr_i), .cm_wbit_i(cm_wbit_i),
    .cco_o(cco_o)
  );

  task automatic chk(input logic act, input logic exp, input string req, input int pos);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos %0d actual %0b expected %0b", req, pos, act, exp);
    end
  endtask

  function automatic logic expb(input int k, input int cpf);
    int s = k % NS;
    int c = k / NS;
    return mdl[s * cpf + (c + 1) % cpf];
  endfunction

  task automatic load(input int cpf, input int mode);
    for (int a = 0; a < NS * cpf; a++) begin
      @(negedge clk);
      cm_we_i    = 1'b1;
      cm_waddr_i = AW'(a);
      cm_wbit_i  = (mode == 0) ? 1'($urandom % 2) : 1'(a == 0 || a == cpf);
      mdl[a]     = cm_wbit_i;
    end
    @(negedge clk);
    cm_we_i = 1'b0;
  endtask

  // Pulse fp with a rate; returns at the negedge where position 0 is visible.
  task automatic start_frame(input logic [1:0] r);
    @(negedge clk);
    fp_i   = 1'b1;
    rate_i = r;
    @(negedge clk);
    fp_i = 1'b0;
  endtask

  task automatic run(input int cpf, input int first, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk(cco_o, expb((first + i) % (NS * cpf), cpf), req, (first + i) % (NS * cpf));
    end
  endtask

  initial begin
    // R8: output low during reset; store loaded while in reset
    load(32, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(cco_o, 1'b0, "R8 reset", i);
    end
    rst = 1'b0;
    @(negedge clk);
    run(32, 0, 600, "R8 post-reset sequence / R6 wrap");

    // Table walk: R1 R2 R3 R4 R5 R6 at every rate code
    for (int t = 0; t < 4; t++) begin
      load(TBL[t][1], 0);
      start_frame(2'(TBL[t][0]));
      run(TBL[t][1], 0, 2 * NS * TBL[t][1], "R1 R2 R3 R6 table");
    end

    // R7: rate change without frame pulse is ignored
    load(32, 0);
    start_frame(2'd0);
    rate_i = 2'd2;
    run(32, 0, 1100, "R7 rate hold");

    // R5: mid-frame restart
    start_frame(2'd0);
    run(32, 0, 100, "R5 pre-restart");
    start_frame(2'd0);
    run(32, 0, 40, "R5 restart");

    // R3: channel 0 bits emitted early in channel 31
    load(32, 1);
    start_frame(2'd0);
    for (int k = 0; k < 512; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 495) chk(cco_o, 1'b0, "R3 before ch31", k);
      if (k == 496) chk(cco_o, 1'b1, "R3 stream0 ch0 at first clock of ch31", k);
      if (k == 497) chk(cco_o, 1'b1, "R3 stream1 ch0 at second clock of ch31", k);
      if (k == 498) chk(cco_o, 1'b0, "R3 stream2 ch0", k);
      if (k == 0)   chk(cco_o, 1'b0, "R3 position 0 carries ch1", k);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule